// File: doc/BRIEF.md
# Belt operand queue

The belt operand queue takes the place of a general-purpose register file. It holds a fixed number of slots. Functional units never name a slot by a fixed address. They name it by its age: position 0 is the value dropped most recently, position 1 the one before it, and so on. Results always enter at the front. Each new value pushes every older value one position further back, and the oldest values fall off the far end. A value is never overwritten in place, so read-after-write hazards on a given slot cannot occur.

Each slot holds a data word and a small metadata record:
- a scalar width code;
- a vector flag;
- a validity kind, which is one of valid, None or NaR.

None marks data that consumers silently skip. NaR marks a fault raised by an earlier operation. The metadata is fixed when the value is dropped and moves with the value unchanged. A read port with its strict input asserted reports a fault when it reads a NaR.

In one cycle, up to `N_DROP` results may be dropped through separate drop ports. All of them appear together after the next clock edge. Any number of read ports (`N_READ`) look up the belt as it stood before that edge. Each read port returns the data and metadata at the requested position.

Top module: `belt_queue`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, every slot is cleared to a None record. After reset, every position reads back as data 0, width 0, vector 0 and kind 0 (None), with fault low. The kind codes are 0 = None, 1 = valid, 2 = NaR.
- R2: A cycle with exactly one valid drop puts that value at position 0 after the next edge. The value that was at position p before the edge is found at position p+1.
- R3: A cycle with n valid drop ports shifts the older entries back by n. The valid ports are compacted so that the lowest-numbered valid port lands at position 0, the next valid port at position 1, and so on, even when invalid ports lie between them.
- R4: Values pushed beyond position `BELT_LEN`-1 are discarded. After more than `BELT_LEN` drops, only the `BELT_LEN` newest values can still be read.
- R5: Reads are combinational on the stored belt. In the cycle a drop is presented, reads still return the pre-drop contents. The dropped values become visible only after the next rising edge.
- R6: The width code, vector flag and kind given with a dropped value come back unchanged at every position that value later occupies.
- R7: A read at a position equal to or above the number of values dropped since reset (capped at `BELT_LEN`) returns a None record: all fields 0. This includes the out-of-range position `BELT_LEN`.
- R8: A cycle with no valid drop leaves every position unchanged.
- R9: `rd_fault` of a port is 1 exactly when that port's `rd_strict` is 1 and the value it reads has kind NaR (2). A None or valid value never raises the fault, whatever the strict input.
- R10: Every read port addresses the belt independently. Two ports reading different positions in the same cycle each return their own position's contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| drop_valid | input | N_DROP | Per drop port: a result is being dropped |
| drop_data | input | N_DROP*DATA_W | Data word of each drop port |
| drop_width | input | N_DROP*3 | Scalar width code of each drop port |
| drop_vec | input | N_DROP | Vector flag of each drop port |
| drop_kind | input | N_DROP*2 | Validity kind of each drop port (0 None, 1 valid, 2 NaR) |
| rd_pos | input | N_READ*($clog2(BELT_LEN)+1) | Belt position requested by each read port |
| rd_strict | input | N_READ | The reading operation must flag a NaR operand |
| rd_data | output | N_READ*DATA_W | Data word at the requested position |
| rd_width | output | N_READ*3 | Width code at the requested position |
| rd_vec | output | N_READ | Vector flag at the requested position |
| rd_kind | output | N_READ*2 | Validity kind at the requested position |
| rd_fault | output | N_READ | Strict read of a NaR value |

## Verification
The bench builds the queue with an 8-slot belt, 64-bit data, three drop ports and two read ports. With 8 slots, a handful of multi-result cycles is enough to push values off the back end and to reach the out-of-range position 8. Three drop ports make a sparse pattern with a hole in the middle (ports 0 and 2 valid) possible, which exercises the compaction order. Two read ports allow simultaneous reads at unrelated positions, and also a read in the same cycle as a drop.

// File: rtl/belt_pkg.sv
`timescale 1ns/1ps
// Shared types for the belt operand queue.
// Assumes: a 2-bit kind code and a 3-bit width code are wide enough for every
// consumer of the belt.
package belt_pkg;

    typedef enum logic [1:0] {
        KIND_NONE  = 2'd0,
        KIND_VALID = 2'd1,
        KIND_NAR   = 2'd2,
        KIND_RSVD  = 2'd3
    } kind_e;

    typedef struct packed {
        logic [2:0] width;
        logic       vec;
        kind_e      kind;
    } meta_t;

    localparam meta_t META_EMPTY = '{width: 3'd0, vec: 1'b0, kind: KIND_NONE};

endpackage

// File: rtl/belt_drop_pack.sv
`timescale 1ns/1ps
// Compacts the valid drop ports of one cycle into a dense list.
// The lowest-numbered valid port is placed first.
// Assumes: N_DROP >= 1. The invalid tail of the list is zero.
module belt_drop_pack
    import belt_pkg::*;
#(
    parameter int N_DROP = 3,
    parameter int DATA_W = 64,
    localparam int CNT_W = $clog2(N_DROP + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_DROP-1:0] in_valid,
    input  logic [DATA_W-1:0] in_data  [N_DROP],
    input  meta_t             in_meta  [N_DROP],
    output logic [N_DROP-1:0] pk_valid,
    output logic [DATA_W-1:0] pk_data  [N_DROP],
    output meta_t             pk_meta  [N_DROP],
    output logic [CNT_W-1:0]  n_new
);

    // Walk the ports in ascending order and append each valid one to the list.
    always_comb begin
        int cnt;
        cnt = 0;
        pk_valid = '0;
        for (int k = 0; k < N_DROP; k++) begin
            pk_data[k] = '0;
            pk_meta[k] = META_EMPTY;
        end
        for (int j = 0; j < N_DROP; j++) begin
            if (in_valid[j]) begin
                for (int k = 0; k < N_DROP; k++) begin
                    if (k == cnt) begin
                        pk_data[k]  = in_data[j];
                        pk_meta[k]  = in_meta[j];
                        pk_valid[k] = 1'b1;
                    end
                end
                cnt++;
            end
        end
        n_new = CNT_W'(cnt);
    end

    // The packed list never has a hole: each entry needs the one before it.
    for (genvar k = 1; k < N_DROP; k++) begin : g_dense
        // R3
        pack_dense_chk: assert property (@(posedge clk) disable iff (!rst_n)
            pk_valid[k] |-> pk_valid[k-1]);
    end

endmodule

// File: rtl/belt_store.sv
`timescale 1ns/1ps
// Slot storage of the belt.
// Each edge, the n_new packed results enter at positions 0..n_new-1 and the
// older contents move back by n_new. Whatever passes position BELT_LEN-1 is
// dropped. A fill count tracks how many positions hold dropped values.
// Assumes: N_DROP <= BELT_LEN. Synchronous active-low reset.
module belt_store
    import belt_pkg::*;
#(
    parameter int BELT_LEN = 8,
    parameter int N_DROP   = 3,
    parameter int DATA_W   = 64,
    localparam int CNT_W   = $clog2(N_DROP + 1),
    localparam int POS_W   = $clog2(BELT_LEN) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] pk_data   [N_DROP],
    input  meta_t             pk_meta   [N_DROP],
    input  logic [CNT_W-1:0]  n_new,
    output logic [DATA_W-1:0] slot_data [BELT_LEN],
    output meta_t             slot_meta [BELT_LEN],
    output logic [POS_W-1:0]  fill
);

    logic [DATA_W-1:0] nxt_data [BELT_LEN];
    meta_t             nxt_meta [BELT_LEN];
    logic [POS_W-1:0]  nxt_fill;

    // Build the next belt by shifting the old contents back by the drop count.
    always_comb begin
        for (int p = 0; p < BELT_LEN; p++) begin
            nxt_data[p] = slot_data[p];
            nxt_meta[p] = slot_meta[p];
        end
        for (int s = 1; s <= N_DROP; s++) begin
            if (n_new == CNT_W'(s)) begin
                for (int p = 0; p < s; p++) begin
                    nxt_data[p] = pk_data[p];
                    nxt_meta[p] = pk_meta[p];
                end
                for (int p = s; p < BELT_LEN; p++) begin
                    nxt_data[p] = slot_data[p-s];
                    nxt_meta[p] = slot_meta[p-s];
                end
            end
        end
    end

    // Add the drop count to the fill level, saturating at the belt length.
    always_comb begin
        int sum;
        sum = int'(fill) + int'(n_new);
        nxt_fill = (sum >= BELT_LEN) ? POS_W'(BELT_LEN) : POS_W'(sum);
    end

    // Register the slots and the fill level; reset turns every slot to None.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int p = 0; p < BELT_LEN; p++) begin
                slot_data[p] <= '0;
                slot_meta[p] <= META_EMPTY;
            end
            fill <= '0;
        end else begin
            for (int p = 0; p < BELT_LEN; p++) begin
                slot_data[p] <= nxt_data[p];
                slot_meta[p] <= nxt_meta[p];
            end
            fill <= nxt_fill;
        end
    end

    for (genvar i = 0; i < BELT_LEN; i++) begin : g_slot_chk
        // R8
        idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (n_new == '0) |=> (slot_data[i] == $past(slot_data[i]))
                              && (slot_meta[i] == $past(slot_meta[i])));
        if (i > 0) begin : g_move
            // R2 R6
            shift_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (n_new == CNT_W'(1)) |=> (slot_data[i] == $past(slot_data[i-1]))
                                         && (slot_meta[i] == $past(slot_meta[i-1])));
        end
    end

    // R7
    fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= POS_W'(BELT_LEN));

endmodule

// File: rtl/belt_read_port.sv
`timescale 1ns/1ps
// One read port. It selects the slot at a belt position. It returns a None
// record for positions at or beyond the fill level, and raises a fault when
// a strict reader meets a NaR.
// Assumes: the position is an age index, 0 being the newest value.
module belt_read_port
    import belt_pkg::*;
#(
    parameter int BELT_LEN = 8,
    parameter int DATA_W   = 64,
    localparam int POS_W   = $clog2(BELT_LEN) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] slot_data [BELT_LEN],
    input  meta_t             slot_meta [BELT_LEN],
    input  logic [POS_W-1:0]  fill,
    input  logic [POS_W-1:0]  pos,
    input  logic              strict,
    output logic [DATA_W-1:0] out_data,
    output meta_t             out_meta,
    output logic              fault
);

    // Select the addressed slot when it lies inside the filled part of the belt.
    always_comb begin
        out_data = '0;
        out_meta = META_EMPTY;
        for (int p = 0; p < BELT_LEN; p++) begin
            if ((pos == POS_W'(p)) && (pos < fill)) begin
                out_data = slot_data[p];
                out_meta = slot_meta[p];
            end
        end
    end

    // Flag a NaR operand only for readers that asked for it.
    always_comb fault = strict && (out_meta.kind == KIND_NAR);

    // R7
    oob_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pos >= fill) |-> ((out_data == '0) && (out_meta == META_EMPTY) && !fault));

    // R9
    fault_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> (strict && (pos < fill)));

endmodule

// File: rtl/belt_queue.sv
`timescale 1ns/1ps
// Top of the belt operand queue. It unpacks the flat drop ports, compacts
// the valid drops, stores them in age order and serves N_READ read ports.
// Assumes: BELT_LEN is 8, 16 or 32, and N_DROP <= BELT_LEN. Synchronous
// active-low reset.
module belt_queue
    import belt_pkg::*;
#(
    parameter int BELT_LEN = 8,
    parameter int DATA_W   = 64,
    parameter int N_DROP   = 3,
    parameter int N_READ   = 2
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic [N_DROP-1:0]                      drop_valid,
    input  logic [N_DROP*DATA_W-1:0]               drop_data,
    input  logic [N_DROP*3-1:0]                    drop_width,
    input  logic [N_DROP-1:0]                      drop_vec,
    input  logic [N_DROP*2-1:0]                    drop_kind,
    input  logic [N_READ*($clog2(BELT_LEN)+1)-1:0] rd_pos,
    input  logic [N_READ-1:0]                      rd_strict,
    output logic [N_READ*DATA_W-1:0]               rd_data,
    output logic [N_READ*3-1:0]                    rd_width,
    output logic [N_READ-1:0]                      rd_vec,
    output logic [N_READ*2-1:0]                    rd_kind,
    output logic [N_READ-1:0]                      rd_fault
);

    localparam int POS_W = $clog2(BELT_LEN) + 1;
    localparam int CNT_W = $clog2(N_DROP + 1);

    logic [DATA_W-1:0] in_data   [N_DROP];
    meta_t             in_meta   [N_DROP];
    logic [N_DROP-1:0] pk_valid;
    logic [DATA_W-1:0] pk_data   [N_DROP];
    meta_t             pk_meta   [N_DROP];
    logic [CNT_W-1:0]  n_new;
    logic [DATA_W-1:0] slot_data [BELT_LEN];
    meta_t             slot_meta [BELT_LEN];
    logic [POS_W-1:0]  fill;

    // Split the flat drop buses into one record per port.
    always_comb begin
        for (int j = 0; j < N_DROP; j++) begin
            in_data[j] = drop_data[j*DATA_W +: DATA_W];
            in_meta[j] = '{width: drop_width[j*3 +: 3],
                           vec:   drop_vec[j],
                           kind:  kind_e'(drop_kind[j*2 +: 2])};
        end
    end

    belt_drop_pack #(.N_DROP(N_DROP), .DATA_W(DATA_W)) u_pack (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (drop_valid),
        .in_data  (in_data),
        .in_meta  (in_meta),
        .pk_valid (pk_valid),
        .pk_data  (pk_data),
        .pk_meta  (pk_meta),
        .n_new    (n_new)
    );

    belt_store #(.BELT_LEN(BELT_LEN), .N_DROP(N_DROP), .DATA_W(DATA_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .pk_data   (pk_data),
        .pk_meta   (pk_meta),
        .n_new     (n_new),
        .slot_data (slot_data),
        .slot_meta (slot_meta),
        .fill      (fill)
    );

    for (genvar r = 0; r < N_READ; r++) begin : g_rd
        logic [DATA_W-1:0] r_data;
        meta_t             r_meta;
        logic              r_fault;

        belt_read_port #(.BELT_LEN(BELT_LEN), .DATA_W(DATA_W)) u_port (
            .clk       (clk),
            .rst_n     (rst_n),
            .slot_data (slot_data),
            .slot_meta (slot_meta),
            .fill      (fill),
            .pos       (rd_pos[r*POS_W +: POS_W]),
            .strict    (rd_strict[r]),
            .out_data  (r_data),
            .out_meta  (r_meta),
            .fault     (r_fault)
        );

        // Place this port's result on the flat output buses.
        always_comb begin
            rd_data[r*DATA_W +: DATA_W] = r_data;
            rd_width[r*3 +: 3]          = r_meta.width;
            rd_vec[r]                   = r_meta.vec;
            rd_kind[r*2 +: 2]           = r_meta.kind;
            rd_fault[r]                 = r_fault;
        end
    end

    // R3
    drop_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(drop_valid) == int'(n_new));

endmodule

// File: tb/belt_queue_test.sv
`timescale 1ns/1ps
// Directed bench for belt_queue: one task per scenario, checked against a
// small age-ordered model built from the requirements.
module belt_queue_test;

    localparam int LEN = 8;
    localparam int DW  = 64;
    localparam int ND  = 3;
    localparam int NR  = 2;
    localparam int PW  = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic [ND-1:0]    drop_valid = '0;
    logic [ND*DW-1:0] drop_data  = '0;
    logic [ND*3-1:0]  drop_width = '0;
    logic [ND-1:0]    drop_vec   = '0;
    logic [ND*2-1:0]  drop_kind  = '0;
    logic [NR*PW-1:0] rd_pos     = '0;
    logic [NR-1:0]    rd_strict  = '0;
    logic [NR*DW-1:0] rd_data;
    logic [NR*3-1:0]  rd_width;
    logic [NR-1:0]    rd_vec;
    logic [NR*2-1:0]  rd_kind;
    logic [NR-1:0]    rd_fault;

    belt_queue #(.BELT_LEN(LEN), .DATA_W(DW), .N_DROP(ND), .N_READ(NR)) uut (
        .clk(clk), .rst_n(rst_n),
        .drop_valid(drop_valid), .drop_data(drop_data), .drop_width(drop_width),
        .drop_vec(drop_vec), .drop_kind(drop_kind),
        .rd_pos(rd_pos), .rd_strict(rd_strict),
        .rd_data(rd_data), .rd_width(rd_width), .rd_vec(rd_vec),
        .rd_kind(rd_kind), .rd_fault(rd_fault)
    );

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    // model: meta is {width[2:0], vec, kind[1:0]}
    logic [DW-1:0] m_data [LEN];
    logic [5:0]    m_meta [LEN];

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [69:0] port_val(input int r);
        return {rd_data[r*DW +: DW], rd_width[r*3 +: 3], rd_vec[r], rd_kind[r*2 +: 2]};
    endfunction

    function automatic logic [69:0] model_val(input int p);
        if (p >= LEN) return '0;
        return {m_data[p], m_meta[p]};
    endfunction

    task automatic set_drop(input int j, input logic v, input logic [63:0] d, input logic [5:0] m);
        drop_valid[j]          = v;
        drop_data[j*DW +: DW]  = d;
        drop_width[j*3 +: 3]   = m[5:3];
        drop_vec[j]            = m[2];
        drop_kind[j*2 +: 2]    = m[1:0];
    endtask

    // Clock in the prepared drops, then update the model in port order.
    task automatic commit_drops();
        logic [DW-1:0] nd [LEN];
        logic [5:0]    nm [LEN];
        int n;
        @(posedge clk);
        n = 0;
        for (int j = 0; j < ND; j++) begin
            if (drop_valid[j]) begin
                nd[n] = drop_data[j*DW +: DW];
                nm[n] = {drop_width[j*3 +: 3], drop_vec[j], drop_kind[j*2 +: 2]};
                n++;
            end
        end
        for (int p = n; p < LEN; p++) begin
            nd[p] = m_data[p-n];
            nm[p] = m_meta[p-n];
        end
        for (int p = 0; p < LEN; p++) begin
            m_data[p] = nd[p];
            m_meta[p] = nm[p];
        end
        @(negedge clk);
        drop_valid = '0;
    endtask

    // Read positions 0..LEN through both ports and compare with the model.
    task automatic check_all(input string req);
        for (int p = 0; p <= LEN; p += 2) begin
            @(negedge clk);
            rd_pos[0 +: PW]  = PW'(p);
            rd_pos[PW +: PW] = PW'(p + 1);
            #1;
            chk(req, 128'(port_val(0)), 128'(model_val(p)));
            if (p + 1 <= LEN) chk(req, 128'(port_val(1)), 128'(model_val(p + 1)));
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        for (int p = 0; p < LEN; p++) begin
            m_data[p] = '0;
            m_meta[p] = '0;
        end
        check_all("R1 reset None");
    endtask

    task automatic t_single();
        set_drop(0, 1'b1, 64'hA1, {3'd3, 1'b0, 2'd1});
        commit_drops();
        check_all("R2/R7 single drop");
        set_drop(0, 1'b1, 64'hA2, {3'd4, 1'b1, 2'd1});
        commit_drops();
        check_all("R2/R6 second drop moves first");
    endtask

    task automatic t_multi();
        set_drop(0, 1'b1, 64'hB0, {3'd0, 1'b0, 2'd1});
        set_drop(1, 1'b1, 64'hB1, {3'd1, 1'b1, 2'd2});
        set_drop(2, 1'b1, 64'hB2, {3'd2, 1'b0, 2'd0});
        commit_drops();
        check_all("R3/R6 triple drop order");
        @(negedge clk);
        rd_pos[0 +: PW] = 4'd0;
        #1;
        chk("R3 port0 newest", 128'(rd_data[0 +: DW]), 128'(64'hB0));
    endtask

    task automatic t_sparse();
        set_drop(0, 1'b1, 64'hC0, {3'd1, 1'b0, 2'd1});
        set_drop(1, 1'b0, 64'hDEAD, {3'd7, 1'b1, 2'd2});
        set_drop(2, 1'b1, 64'hC2, {3'd2, 1'b1, 2'd1});
        commit_drops();
        check_all("R3 sparse compaction");
        @(negedge clk);
        rd_pos[PW +: PW] = 4'd1;
        #1;
        chk("R3 port2 at pos1", 128'(rd_data[DW +: DW]), 128'(64'hC2));
    endtask

    task automatic t_idle();
        repeat (3) @(posedge clk);
        check_all("R8 idle hold");
    endtask

    task automatic t_same_cycle();
        logic [63:0] old0;
        @(negedge clk);
        old0 = m_data[0];
        set_drop(0, 1'b1, 64'hE5, {3'd3, 1'b0, 2'd1});
        rd_pos[0 +: PW] = 4'd0;
        #1;
        chk("R5 pre-edge read sees old", 128'(rd_data[0 +: DW]), 128'(old0));
        commit_drops();
        #1;
        chk("R5 post-edge read sees new", 128'(rd_data[0 +: DW]), 128'(64'hE5));
    endtask

    task automatic t_overflow();
        for (int k = 0; k < 4; k++) begin
            for (int j = 0; j < ND; j++)
                set_drop(j, 1'b1, 64'h100 + 64'(k*ND + j), {3'(j), 1'(k), 2'd1});
            commit_drops();
        end
        check_all("R4 overflow keeps newest");
        @(negedge clk);
        rd_pos[0 +: PW] = 4'd7;
        rd_pos[PW +: PW] = 4'd8;
        #1;
        chk("R4 oldest kept", 128'(rd_data[0 +: DW]), 128'(64'h104));
        chk("R7 position LEN is None", 128'(port_val(1)), 128'(0));
    endtask

    task automatic t_fault();
        set_drop(0, 1'b1, 64'hF0, {3'd3, 1'b0, 2'd2});
        set_drop(1, 1'b1, 64'hF1, {3'd3, 1'b0, 2'd0});
        set_drop(2, 1'b1, 64'hF2, {3'd3, 1'b0, 2'd1});
        commit_drops();
        for (int p = 0; p < 3; p++) begin
            @(negedge clk);
            rd_pos[0 +: PW]  = PW'(p);
            rd_pos[PW +: PW] = PW'(p);
            rd_strict = 2'b01;
            #1;
            chk("R9 strict fault", 128'(rd_fault[0]), 128'(p == 0));
            chk("R9 lax no fault", 128'(rd_fault[1]), 128'(0));
        end
        rd_strict = '0;
    endtask

    task automatic t_ports();
        @(negedge clk);
        rd_pos[0 +: PW]  = 4'd5;
        rd_pos[PW +: PW] = 4'd2;
        #1;
        chk("R10 port0 pos5", 128'(port_val(0)), 128'(model_val(5)));
        chk("R10 port1 pos2", 128'(port_val(1)), 128'(model_val(2)));
    endtask

    initial begin
        t_reset();
        t_single();
        t_multi();
        t_sparse();
        t_idle();
        t_same_cycle();
        t_overflow();
        t_fault();
        t_ports();
        t_reset();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule